// File: doc/BRIEF.md
# IO Rail Deep-Powerdown Controller

This block holds up to sixty pad rails, split into two banks of thirty, and moves selected rails into or out of deep powerdown on command from software. Software reaches it through a simple APB-style register port. It arms the operation through a sample-enable bit and programs a settle delay in bus clock cycles, sized to cover at least 200 ns. It then writes a request word. The low bits of that word pick rails and the top two bits carry the command.

After an accepted request the block counts down the programmed delay. When the count ends, every selected rail's status bit and pad powerdown output change together. The command then reads back as idle and the sample-enable bit clears, so software can poll either one for completion. A request that arrives while a delay is still running is held and started as soon as the running one completes.

Top module: `io_rail_dpd_ctrl`

## Requirements
- R1: After reset every register reads 0 and every bit of `pad_dpd` is 0, meaning all rails are powered.
- R2: The sample-enable flag is bit 0 at address 0x020. The delay register at 0x1C8 holds TIM_W bits. Both read back what was written. Bits 29:0 of a request register read back the rail selection from the last write to it.
- R3: Bank 0 has its request at 0x1B8 and its status at 0x1BC. Bank 1 has its request at 0x1C0 and its status at 0x1C4. Status bit k of bank b is driven on `pad_dpd[b*30+k]`. A 1 means the rail is in deep powerdown.
- R4: Command 2 (bits 31:30 = 2'b10) sets the status bit of every selected rail. Command 1 (2'b01) clears it. Unselected rails keep their state.
- R5: An accepted request takes effect exactly max(delay,1) bus clock edges after the edge that completes its write. Status and pads stay unchanged until then.
- R6: A request write with command 0 or 3, or written while sample-enable is 0, starts nothing and leaves all status bits and pads unchanged.
- R7: The command field of a request register reads the queued code while that request is held or counting. It reads 0 once the request has been applied, and 0 after a rejected write.
- R8: Sample-enable returns to 0 on the edge that applies a request, unless software writes that register on the same edge.
- R9: A request accepted while a delay is running is held. It starts counting, with the delay value current at that moment, on the edge where the running one is applied. A later held request replaces an earlier one.
- R10: The status registers are read-only. Writes to them change neither status nor pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock; also times the settle delay |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pad_dpd | output | 2*RAILS | Per-rail deep-powerdown control, bank 1 in the upper half |

## Verification
The only result that is due later than the access itself is the status and pad update. It lands max(delay,1) edges after the access edge. A held request adds the remaining count of the running one before its own count begins. Register readback is combinational within the access phase, so the bench samples `prdata` at the falling edge inside it. For pads, the bench steps one falling edge at a time after each accepted write. Before the due edge it expects the old value, and from the due edge on it expects the new one, so an update one cycle early or late fails. Rejected writes are followed by several idle cycles and a status readback.

// File: rtl/io_rail_dpd_ctrl.sv
module io_rail_dpd_ctrl #(
  parameter int ADDR_W = 12,
  parameter int RAILS  = 30,
  parameter int TIM_W  = 16
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic [2*RAILS-1:0]   pad_dpd
);
  localparam logic [ADDR_W-1:0] A_SAMP = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_REQ0 = ADDR_W'(12'h1B8);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(12'h1BC);
  localparam logic [ADDR_W-1:0] A_REQ1 = ADDR_W'(12'h1C0);
  localparam logic [ADDR_W-1:0] A_ST1  = ADDR_W'(12'h1C4);
  localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(12'h1C8);
  localparam logic [1:0] C_LEAVE = 2'd1;
  localparam logic [1:0] C_ENTER = 2'd2;
  localparam int PADW = 30 - RAILS;

  logic             samp_en;
  logic [TIM_W-1:0] tim, cnt;
  logic [RAILS-1:0] sel0, sel1, stat0, stat1;
  logic             busy, act_bank, pend_v, pend_bank;
  logic [1:0]       act_code, pend_code;
  logic [RAILS-1:0] act_mask, pend_mask;

  logic             wr, wr_req0, wr_req1, samp_wr, acc, done, free;
  logic [1:0]       in_code;
  logic [TIM_W-1:0] tim_eff;
  logic [1:0]       code0_rd, code1_rd;

  assign wr      = psel & penable & pwrite;
  assign wr_req0 = wr && paddr == A_REQ0;
  assign wr_req1 = wr && paddr == A_REQ1;
  assign samp_wr = wr && paddr == A_SAMP;
  assign in_code = pwdata[31:30];
  assign acc     = (wr_req0 | wr_req1) && samp_en && (in_code == C_LEAVE || in_code == C_ENTER);
  assign done    = busy && cnt == TIM_W'(1);
  assign free    = !busy || done;
  assign tim_eff = (tim == '0) ? TIM_W'(1) : tim;
  assign pad_dpd = {stat1, stat0};

  assign code0_rd = (busy && !act_bank) ? act_code :
                    (pend_v && !pend_bank) ? pend_code : 2'd0;
  assign code1_rd = (busy && act_bank) ? act_code :
                    (pend_v && pend_bank) ? pend_code : 2'd0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      samp_en   <= 1'b0;
      tim       <= '0;
      cnt       <= '0;
      sel0      <= '0;
      sel1      <= '0;
      stat0     <= '0;
      stat1     <= '0;
      busy      <= 1'b0;
      act_bank  <= 1'b0;
      act_code  <= 2'd0;
      act_mask  <= '0;
      pend_v    <= 1'b0;
      pend_bank <= 1'b0;
      pend_code <= 2'd0;
      pend_mask <= '0;
    end else begin
      if (wr && paddr == A_TIM) tim <= pwdata[TIM_W-1:0];
      if (wr_req0) sel0 <= pwdata[RAILS-1:0];
      if (wr_req1) sel1 <= pwdata[RAILS-1:0];

      if (samp_wr)   samp_en <= pwdata[0];
      else if (done) samp_en <= 1'b0;

      if (done) begin
        if (act_bank) stat1 <= (act_code == C_ENTER) ? (stat1 | act_mask) : (stat1 & ~act_mask);
        else          stat0 <= (act_code == C_ENTER) ? (stat0 | act_mask) : (stat0 & ~act_mask);
      end

      if (free) begin
        if (pend_v) begin
          busy     <= 1'b1;
          cnt      <= tim_eff;
          act_bank <= pend_bank;
          act_code <= pend_code;
          act_mask <= pend_mask;
          pend_v   <= acc;
          if (acc) begin
            pend_bank <= wr_req1;
            pend_code <= in_code;
            pend_mask <= pwdata[RAILS-1:0];
          end
        end else if (acc) begin
          busy     <= 1'b1;
          cnt      <= tim_eff;
          act_bank <= wr_req1;
          act_code <= in_code;
          act_mask <= pwdata[RAILS-1:0];
        end else begin
          busy <= 1'b0;
        end
      end else begin
        cnt <= cnt - TIM_W'(1);
        if (acc) begin
          pend_v    <= 1'b1;
          pend_bank <= wr_req1;
          pend_code <= in_code;
          pend_mask <= pwdata[RAILS-1:0];
        end
      end
    end
  end

  always_comb begin
    prdata = 32'd0;
    if (psel) begin
      case (paddr)
        A_SAMP: prdata = {31'd0, samp_en};
        A_REQ0: prdata = {code0_rd, {PADW{1'b0}}, sel0};
        A_ST0:  prdata = {2'd0, {PADW{1'b0}}, stat0};
        A_REQ1: prdata = {code1_rd, {PADW{1'b0}}, sel1};
        A_ST1:  prdata = {2'd0, {PADW{1'b0}}, stat1};
        A_TIM:  prdata = {{(32-TIM_W){1'b0}}, tim};
        default: prdata = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/io_rail_dpd_chk.sv
module io_rail_dpd_chk #(
  parameter int RAILS = 30,
  parameter int TIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [TIM_W-1:0] cnt,
  input logic [RAILS-1:0] stat0,
  input logic [RAILS-1:0] stat1,
  input logic             samp_en,
  input logic             samp_wr,
  input logic             act_bank,
  input logic [1:0]       act_code,
  input logic [RAILS-1:0] act_mask
);
  logic due;
  assign due = busy && cnt == TIM_W'(1);

  a_r5_hold_until_due: assert property (@(posedge clk) disable iff (!rst_n)
    !due |=> $stable({stat1, stat0}));

  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0);

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (act_code == 2'd1 || act_code == 2'd2));

  a_r8_samp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !samp_wr) |=> !samp_en);

  a_r4_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (due && act_code == 2'd2 && !act_bank) |=> ((stat0 & $past(act_mask)) == $past(act_mask)));

  a_r4_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (due && act_code == 2'd1 && act_bank) |=> ((stat1 & $past(act_mask)) == '0));
endmodule

bind io_rail_dpd_ctrl io_rail_dpd_chk #(.RAILS(RAILS), .TIM_W(TIM_W)) u_chk (
  .clk(pclk), .rst_n(presetn), .busy(busy), .cnt(cnt), .stat0(stat0), .stat1(stat1),
  .samp_en(samp_en), .samp_wr(samp_wr), .act_bank(act_bank), .act_code(act_code),
  .act_mask(act_mask)
);

// File: tb/test_io_rail_dpd_ctrl.sv
module test_io_rail_dpd_ctrl;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [59:0] pad_dpd;
  logic [59:0] model = '0;
  int checks = 0, errors = 0;

  always #10 pclk = ~pclk;

  io_rail_dpd_ctrl i_io_rail_dpd_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_dpd(pad_dpd)
  );

  function automatic logic [59:0] apply_cmd(logic [59:0] cur, bit bank, logic [1:0] code, logic [29:0] sel);
    logic [59:0] m;
    m = bank ? {sel, 30'd0} : {30'd0, sel};
    if (code == 2'd2) return cur | m;
    if (code == 2'd1) return cur & ~m;
    return cur;
  endfunction

  function automatic int eff(int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin d = prdata; psel = 0; penable = 0; end
  endtask

  task automatic check_regs(string req);
    logic [31:0] d;
    rd(12'h1BC, d); chk(req, d, {2'b0, model[29:0]});
    rd(12'h1C4, d); chk(req, d, {2'b0, model[59:30]});
    chk(req, pad_dpd, model);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    chk("R1 pads", pad_dpd, 60'd0);
    rd(12'h020, d); chk("R1 samp", d, 0);
    rd(12'h1B8, d); chk("R1 req0", d, 0);
    rd(12'h1C0, d); chk("R1 req1", d, 0);
    rd(12'h1C8, d); chk("R1 tim", d, 0);
    check_regs("R1 status");

    // R2 readback
    wr(12'h1C8, 32'hFFFF_ABCD); rd(12'h1C8, d); chk("R2 timer", d, 32'h0000_ABCD);
    wr(12'h020, 32'h1); rd(12'h020, d); chk("R2 samp", d, 1);
    wr(12'h020, 32'h0);
    wr(12'h1C0, 32'h0123_4567); rd(12'h1C0, d); chk("R2 sel", d, 32'h0123_4567);

    // R7 command readback during a long delay, R3 bank-1 pad mapping
    wr(12'h1C8, 20); wr(12'h020, 1);
    wr(12'h1C0, {2'd2, 30'h2000_0001});
    rd(12'h1C0, d); chk("R7 code queued", d, {2'd2, 30'h2000_0001});
    repeat (20) @(negedge pclk);
    model = apply_cmd(model, 1, 2'd2, 30'h2000_0001);
    rd(12'h1C0, d); chk("R7 code idle", d, {2'd0, 30'h2000_0001});
    chk("R3 pad59", pad_dpd[59], 1'b1);
    chk("R3 pad30", pad_dpd[30], 1'b1);
    rd(12'h020, d); chk("R8 samp clear", d, 0);
    check_regs("R3 status");

    // R10 status read-only
    wr(12'h1BC, 32'h3FFF_FFFF); wr(12'h1C4, 32'h0);
    repeat (3) @(negedge pclk);
    check_regs("R10 readonly");

    // R9 held request
    wr(12'h1C8, 10); wr(12'h020, 1);
    wr(12'h1B8, {2'd2, 30'h0000_00F0});
    wr(12'h1C0, {2'd2, 30'h0000_0F00});
    repeat (8) @(negedge pclk);
    model = apply_cmd(model, 0, 2'd2, 30'h0000_00F0);
    chk("R9 first applied", pad_dpd, model);
    repeat (9) @(negedge pclk);
    chk("R9 held not early", pad_dpd, model);
    @(negedge pclk);
    model = apply_cmd(model, 1, 2'd2, 30'h0000_0F00);
    chk("R9 held applied", pad_dpd, model);

    // timer 0 treated as 1
    wr(12'h1C8, 0); wr(12'h020, 1);
    model = apply_cmd(model, 1, 2'd1, 30'h0000_0300);
    wr(12'h1C0, {2'd1, 30'h0000_0300});
    @(negedge pclk);
    chk("R5 zero delay", pad_dpd, model);

    // Random mix: R4 R5 R6 R7 R8
    for (int it = 0; it < 60; it++) begin
      int t;
      bit samp, bank, accepted;
      logic [1:0] code;
      logic [29:0] sel;
      logic [59:0] old;
      t = $urandom % 6;
      samp = ($urandom % 4) != 0;
      bank = $urandom % 2;
      code = 2'($urandom % 4);
      sel = 30'($urandom);
      accepted = samp && (code == 2'd1 || code == 2'd2);
      wr(12'h1C8, t);
      wr(12'h020, {31'd0, samp});
      old = model;
      wr(bank ? 12'h1C0 : 12'h1B8, {code, sel});
      if (accepted) begin
        model = apply_cmd(old, bank, code, sel);
        for (int k = 1; k <= eff(t); k++) begin
          @(negedge pclk);
          if (k < eff(t)) chk("R5 before due", pad_dpd, old);
          else chk("R4 applied on due edge", pad_dpd, model);
        end
      end else begin
        repeat (4) @(negedge pclk);
        chk("R6 rejected no effect", pad_dpd, model);
      end
      check_regs(accepted ? "R4 status" : "R6 status");
      rd(12'h020, d); chk("R8 samp after", d, accepted ? 0 : {31'd0, samp});
      rd(bank ? 12'h1C0 : 12'h1B8, d); chk("R7 code idle", d, {2'd0, sel});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule